// File: doc/BRIEF.md
# Sequential Burst Write Front-End

This block takes a stream of words from a user and writes them to memory as bursts to consecutive addresses. A transfer opens when the user raises a write request with a start address. While the request stays high, the user pushes words into an internal buffer whenever the block shows write-ready. The block turns the buffered words into memory write commands, each with an address and a length, and streams the data beats after each command is accepted.

A burst is issued only when the buffer holds a full burst. If fewer words are present and the request is still high, the block waits for more data instead of starting a partial burst. When the user drops the request, the leftover words go out as one shorter burst and the transfer closes.

A refresh request from the memory side is taken only between bursts. The user sees refresh only as write-ready being held low while it is serviced. The memory port is a plain command handshake. Data beats follow the command with no backpressure.

Top module: `burst_wr_frontend`

## Requirements
- R1: While reset is held and after it is released, `usr_ready`, `mem_cmd_valid`, `mem_wdata_valid` and `ref_ack` are 0.
- R2: `usr_ready` is 1 only while a transfer is open, `usr_req` is high, no refresh is being serviced and the buffer has at least 2 free entries. With the default depth of 16 and no draining, at most 15 words are accepted.
- R3: A push is stored only when `usr_push` and `usr_ready` are both 1 at a rising clock edge. Any other push is discarded and never reaches memory.
- R4: The first command of a transfer carries the `usr_start_addr` value sampled in the cycle the transfer opened. Each later command's address equals the previous command's address plus its length.
- R5: When a transfer is open and the buffer holds at least BL words (default 4), a command of length BL is issued.
- R6: While `usr_req` is high and the buffer holds fewer than BL words, no command is issued.
- R7: After `usr_req` falls, any remaining words (1 to BL-1) are sent as one command whose length equals that word count. The transfer then closes, and no further command appears until a new request.
- R8: While `mem_cmd_valid` is high and `mem_cmd_ready` is low, `mem_cmd_valid`, `mem_cmd_addr` and `mem_cmd_len` stay unchanged.
- R9: After a command is accepted (`mem_cmd_valid` and `mem_cmd_ready` at an edge), `mem_wdata_valid` is high for exactly `mem_cmd_len` consecutive cycles starting the next cycle. The words come out in the order they were accepted.
- R10: A `ref_req` is honoured only between bursts. While honoured, `ref_ack` stays high until `ref_req` falls, and during that time no command or data beat is issued and `usr_ready` is 0.
- R11: Every command has `mem_cmd_wr` = 1. `mem_cmd_len` is a plain word count from 1 to BL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| usr_req | input | 1 | Write request; transfer stays open while high |
| usr_start_addr | input | AW | Start word address, sampled when a transfer opens |
| usr_ready | output | 1 | Buffer may accept a word this cycle |
| usr_push | input | 1 | Push a word into the buffer |
| usr_data | input | DW | Word being pushed |
| ref_req | input | 1 | Refresh request from the memory side |
| ref_ack | output | 1 | Refresh granted; held while `ref_req` is high |
| mem_cmd_valid | output | 1 | Write command present |
| mem_cmd_ready | input | 1 | Memory accepts the command |
| mem_cmd_addr | output | AW | Burst start address |
| mem_cmd_len | output | LW | Burst length in words (1..BL) |
| mem_cmd_wr | output | 1 | Write flag, always 1 with a command |
| mem_wdata_valid | output | 1 | Data beat present |
| mem_wdata | output | DW | Data beat |

## Verification
The main function is tested with several word counts:
- An exact multiple of BL, which shows full-burst issue and that the transfer closes cleanly with nothing left.
- A count that leaves a remainder, which separates waiting while the request is high from flushing once it falls.
- Pushes against a buffer that is not draining, which exposes the free-space threshold and confirms that rejected words never reach memory.

Refresh is raised at two points. Raised while the block is idle inside a transfer, it tests gating of `usr_ready` and commands. Raised while a command is stalled, it tests that a burst in flight is not broken.

// File: rtl/burst_wr_pkg.sv
package burst_wr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_CMD,
    ST_DATA,
    ST_REF
  } bwf_state_e;
endpackage

// File: rtl/bwf_fifo.sv
module bwf_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] fill
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] fill_q, fill_d;

  always_comb begin
    wr_d   = wr_q;
    rd_d   = rd_q;
    fill_d = fill_q;
    if (push) begin
      wr_d = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    end
    if (pop) begin
      rd_d = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    end
    case ({push, pop})
      2'b10:   fill_d = fill_q + 1'b1;
      2'b01:   fill_d = fill_q - 1'b1;
      default: fill_d = fill_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      rd_q   <= '0;
      fill_q <= '0;
    end else begin
      wr_q   <= wr_d;
      rd_q   <= rd_d;
      fill_q <= fill_d;
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (push && (wr_q == PW'(g))) begin
          mem_q[g] <= wdata;
        end
      end
    end
  endgenerate

  assign rdata = mem_q[rd_q];
  assign fill  = fill_q;
endmodule

// File: rtl/bwf_addr_gen.sv
module bwf_addr_gen #(
  parameter int AW = 16,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] start_addr,
  input  logic          adv,
  input  logic [LW-1:0] step,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] addr_q, addr_d;

  always_comb begin
    addr_d = addr_q;
    if (load) begin
      addr_d = start_addr;
    end else if (adv) begin
      addr_d = addr_q + AW'(step);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (load || adv) begin
      addr_q <= addr_d;
    end
  end

  assign addr = addr_q;
endmodule

// File: rtl/bwf_ctrl.sv
module bwf_ctrl
  import burst_wr_pkg::*;
#(
  parameter int BL    = 4,
  parameter int DEPTH = 16,
  localparam int LW   = $clog2(BL + 1),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          usr_req,
  input  logic [CW-1:0] fill,
  input  logic          ref_req,
  input  logic          mem_cmd_ready,
  output logic          load_addr,
  output logic          adv_addr,
  output logic [LW-1:0] burst_len,
  output logic          pop,
  output logic          cmd_valid,
  output logic          beat_valid,
  output logic          ref_ack,
  output logic          xfer_open
);
  bwf_state_e    st_q, st_d;
  logic [LW-1:0] len_q, len_d;
  logic [LW-1:0] beat_q, beat_d;
  logic          last_beat;

  assign last_beat = (beat_q == len_q - 1'b1);

  always_comb begin
    st_d      = st_q;
    len_d     = len_q;
    beat_d    = beat_q;
    load_addr = 1'b0;
    adv_addr  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (usr_req) begin
          load_addr = 1'b1;
          st_d      = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (ref_req) begin
          st_d = ST_REF;
        end else if (fill >= CW'(BL)) begin
          len_d = LW'(BL);
          st_d  = ST_CMD;
        end else if (!usr_req) begin
          if (fill != '0) begin
            len_d = LW'(fill);
            st_d  = ST_CMD;
          end else begin
            st_d = ST_IDLE;
          end
        end
      end
      ST_CMD: begin
        if (mem_cmd_ready) begin
          beat_d = '0;
          st_d   = ST_DATA;
        end
      end
      ST_DATA: begin
        beat_d = beat_q + 1'b1;
        if (last_beat) begin
          adv_addr = 1'b1;
          st_d     = ST_WAIT;
        end
      end
      ST_REF: begin
        if (!ref_req) begin
          st_d = ST_WAIT;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      len_q  <= '0;
      beat_q <= '0;
    end else begin
      st_q   <= st_d;
      len_q  <= len_d;
      beat_q <= beat_d;
    end
  end

  assign burst_len  = len_q;
  assign cmd_valid  = (st_q == ST_CMD);
  assign beat_valid = (st_q == ST_DATA);
  assign pop        = (st_q == ST_DATA);
  assign ref_ack    = (st_q == ST_REF);
  assign xfer_open  = (st_q != ST_IDLE) && (st_q != ST_REF);
endmodule

// File: rtl/burst_wr_frontend.sv
module burst_wr_frontend #(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int BL    = 4,
  parameter int DEPTH = 16,
  localparam int LW   = $clog2(BL + 1),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          usr_req,
  input  logic [AW-1:0] usr_start_addr,
  output logic          usr_ready,
  input  logic          usr_push,
  input  logic [DW-1:0] usr_data,
  input  logic          ref_req,
  output logic          ref_ack,
  output logic          mem_cmd_valid,
  input  logic          mem_cmd_ready,
  output logic [AW-1:0] mem_cmd_addr,
  output logic [LW-1:0] mem_cmd_len,
  output logic          mem_cmd_wr,
  output logic          mem_wdata_valid,
  output logic [DW-1:0] mem_wdata
);
  logic [CW-1:0] fill;
  logic          push_ok, pop, load_addr, adv_addr, xfer_open;
  logic [LW-1:0] burst_len;

  assign usr_ready = xfer_open && usr_req && (fill <= CW'(DEPTH - 2));
  assign push_ok   = usr_push && usr_ready;

  bwf_fifo #(.DW(DW), .DEPTH(DEPTH)) u_buf (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push_ok),
    .wdata (usr_data),
    .pop   (pop),
    .rdata (mem_wdata),
    .fill  (fill)
  );

  bwf_addr_gen #(.AW(AW), .LW(LW)) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load_addr),
    .start_addr (usr_start_addr),
    .adv        (adv_addr),
    .step       (burst_len),
    .addr       (mem_cmd_addr)
  );

  bwf_ctrl #(.BL(BL), .DEPTH(DEPTH)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .usr_req       (usr_req),
    .fill          (fill),
    .ref_req       (ref_req),
    .mem_cmd_ready (mem_cmd_ready),
    .load_addr     (load_addr),
    .adv_addr      (adv_addr),
    .burst_len     (burst_len),
    .pop           (pop),
    .cmd_valid     (mem_cmd_valid),
    .beat_valid    (mem_wdata_valid),
    .ref_ack       (ref_ack),
    .xfer_open     (xfer_open)
  );

  assign mem_cmd_len = burst_len;
  assign mem_cmd_wr  = mem_cmd_valid;
endmodule

// File: rtl/bwf_checker.sv
module bwf_checker #(
  parameter int AW = 16,
  parameter int LW = 3,
  parameter int BL = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          usr_req,
  input logic          usr_ready,
  input logic          ref_ack,
  input logic          mem_cmd_valid,
  input logic          mem_cmd_ready,
  input logic [AW-1:0] mem_cmd_addr,
  input logic [LW-1:0] mem_cmd_len,
  input logic          mem_cmd_wr,
  input logic          mem_wdata_valid
);
  // R2
  ready_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    usr_ready |-> usr_req);

  // R8
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd_valid && !mem_cmd_ready) |=>
      (mem_cmd_valid && $stable(mem_cmd_addr) && $stable(mem_cmd_len)));

  // R9
  beat_follows_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd_valid && mem_cmd_ready) |=> (mem_wdata_valid && !mem_cmd_valid));

  // R10
  refresh_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_ack |-> (!mem_cmd_valid && !mem_wdata_valid && !usr_ready));

  // R11
  cmd_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_valid |-> (mem_cmd_wr && (mem_cmd_len != '0) && (mem_cmd_len <= LW'(BL))));
endmodule

bind burst_wr_frontend bwf_checker #(.AW(AW), .LW(LW), .BL(BL)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .usr_req         (usr_req),
  .usr_ready       (usr_ready),
  .ref_ack         (ref_ack),
  .mem_cmd_valid   (mem_cmd_valid),
  .mem_cmd_ready   (mem_cmd_ready),
  .mem_cmd_addr    (mem_cmd_addr),
  .mem_cmd_len     (mem_cmd_len),
  .mem_cmd_wr      (mem_cmd_wr),
  .mem_wdata_valid (mem_wdata_valid)
);

// File: tb/burst_wr_frontend_tb.sv
`timescale 1ns/1ps
module burst_wr_frontend_tb;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int BL = 4;
  localparam int DEPTH = 16;
  localparam int LW = $clog2(BL + 1);

  logic clk, rst_n;
  logic usr_req, usr_push, usr_ready, ref_req, ref_ack;
  logic [AW-1:0] usr_start_addr, mem_cmd_addr;
  logic [DW-1:0] usr_data, mem_wdata;
  logic mem_cmd_valid, mem_cmd_ready, mem_cmd_wr, mem_wdata_valid;
  logic [LW-1:0] mem_cmd_len;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [AW-1:0] c_addr [64];
  int            c_len  [64];
  logic          c_wr   [64];
  logic [DW-1:0] d_got  [64];
  logic [DW-1:0] d_exp  [64];
  int ncmd = 0;
  int ndata = 0;
  int nexp = 0;

  burst_wr_frontend #(.AW(AW), .DW(DW), .BL(BL), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .usr_req(usr_req), .usr_start_addr(usr_start_addr),
    .usr_ready(usr_ready), .usr_push(usr_push), .usr_data(usr_data),
    .ref_req(ref_req), .ref_ack(ref_ack), .mem_cmd_valid(mem_cmd_valid),
    .mem_cmd_ready(mem_cmd_ready), .mem_cmd_addr(mem_cmd_addr),
    .mem_cmd_len(mem_cmd_len), .mem_cmd_wr(mem_cmd_wr),
    .mem_wdata_valid(mem_wdata_valid), .mem_wdata(mem_wdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // monitor: inputs change at negedge, sample 2 ns later
  always @(negedge clk) begin
    #2;
    if (rst_n && mem_cmd_valid && mem_cmd_ready && ncmd < 64) begin
      c_addr[ncmd] = mem_cmd_addr;
      c_len[ncmd]  = int'(mem_cmd_len);
      c_wr[ncmd]   = mem_cmd_wr;
      ncmd++;
    end
    if (rst_n && mem_wdata_valid && ndata < 64) begin
      d_got[ndata] = mem_wdata;
      ndata++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic try_push(input logic [DW-1:0] w, output bit acc);
    @(negedge clk);
    usr_push = 1'b1;
    usr_data = w;
    #1;
    acc = usr_ready;
    if (acc) begin
      d_exp[nexp] = w;
      nexp++;
    end
    @(negedge clk);
    usr_push = 1'b0;
  endtask

  task automatic push_n(input int n, input logic [DW-1:0] base);
    int got = 0;
    int tries = 0;
    bit acc;
    while (got < n && tries < 200) begin
      try_push(base + DW'(got), acc);
      if (acc) got++;
      tries++;
    end
  endtask

  task automatic open_xfer(input logic [AW-1:0] a);
    @(negedge clk);
    usr_req = 1'b1;
    usr_start_addr = a;
    @(negedge clk);
    usr_start_addr = '1;
  endtask

  task automatic close_xfer();
    @(negedge clk);
    usr_req = 1'b0;
  endtask

  task automatic check_data(input int d0, input int e0, input int n, input string req);
    for (int i = 0; i < n; i++) begin
      check(d_got[d0 + i] == d_exp[e0 + i], req, int'(d_got[d0 + i]), int'(d_exp[e0 + i]));
    end
  endtask

  task automatic t_reset();
    check(usr_ready == 1'b0, "R1 usr_ready", int'(usr_ready), 0);
    check(mem_cmd_valid == 1'b0, "R1 cmd_valid", int'(mem_cmd_valid), 0);
    check(mem_wdata_valid == 1'b0, "R1 wdata_valid", int'(mem_wdata_valid), 0);
    check(ref_ack == 1'b0, "R1 ref_ack", int'(ref_ack), 0);
  endtask

  task automatic t_full_bursts();
    int c0 = ncmd, d0 = ndata, e0 = nexp;
    open_xfer(16'h0100);
    push_n(8, 16'hA000);
    cyc(12);
    check(ncmd - c0 == 2, "R5 two full bursts", ncmd - c0, 2);
    check(c_addr[c0] == 16'h0100, "R4 first addr", int'(c_addr[c0]), 'h100);
    check(c_addr[c0 + 1] == 16'h0104, "R4 second addr", int'(c_addr[c0 + 1]), 'h104);
    check(c_len[c0] == 4 && c_len[c0 + 1] == 4, "R5 len", c_len[c0 + 1], 4);
    check(c_wr[c0] == 1'b1, "R11 write flag", int'(c_wr[c0]), 1);
    check(ndata - d0 == 8, "R9 beat count", ndata - d0, 8);
    check_data(d0, e0, 8, "R9 data order");
    close_xfer();
    cyc(10);
    check(ncmd - c0 == 2, "R7 nothing after empty close", ncmd - c0, 2);
  endtask

  task automatic t_short_tail();
    int c0 = ncmd, d0 = ndata, e0 = nexp;
    open_xfer(16'h0200);
    push_n(6, 16'hB000);
    cyc(15);
    check(ncmd - c0 == 1, "R6 no partial while req high", ncmd - c0, 1);
    close_xfer();
    cyc(15);
    check(ncmd - c0 == 2, "R7 flush issued", ncmd - c0, 2);
    check(c_addr[c0 + 1] == 16'h0204, "R4 R7 tail addr", int'(c_addr[c0 + 1]), 'h204);
    check(c_len[c0 + 1] == 2, "R7 tail len", c_len[c0 + 1], 2);
    check_data(d0, e0, 6, "R9 tail data");
    cyc(10);
    check(ncmd - c0 == 2, "R7 closed after flush", ncmd - c0, 2);
  endtask

  task automatic t_backpressure();
    int c0 = ncmd, d0 = ndata, e0 = nexp;
    int acc_n = 0;
    bit acc;
    mem_cmd_ready = 1'b0;
    @(negedge clk);
    usr_push = 1'b1;
    usr_data = 16'hDEAD;
    #1;
    check(usr_ready == 1'b0, "R2 R3 ready low when idle", int'(usr_ready), 0);
    @(negedge clk);
    usr_push = 1'b0;
    open_xfer(16'h0300);
    for (int i = 0; i < 16; i++) begin
      try_push(16'hC000 + DW'(i), acc);
      if (acc) acc_n++;
    end
    check(acc_n == DEPTH - 1, "R2 free-space limit", acc_n, DEPTH - 1);
    check(usr_ready == 1'b0, "R2 ready low when nearly full", int'(usr_ready), 0);
    @(negedge clk);
    mem_cmd_ready = 1'b1;
    usr_req = 1'b0;
    cyc(40);
    check(ncmd - c0 == 4, "R5 R7 drained bursts", ncmd - c0, 4);
    check(c_addr[c0 + 3] == 16'h030C, "R4 fourth addr", int'(c_addr[c0 + 3]), 'h30c);
    check(c_len[c0 + 3] == 3, "R7 last len", c_len[c0 + 3], 3);
    check(ndata - d0 == 15, "R3 rejected words absent", ndata - d0, 15);
    check_data(d0, e0, 15, "R3 data order");
  endtask

  task automatic t_refresh_idle();
    int c0 = ncmd, acc_n = 0;
    bit acc;
    open_xfer(16'h0400);
    @(negedge clk);
    ref_req = 1'b1;
    cyc(3);
    #1;
    check(ref_ack == 1'b1, "R10 ack given", int'(ref_ack), 1);
    check(usr_ready == 1'b0, "R10 ready low", int'(usr_ready), 0);
    for (int i = 0; i < 4; i++) begin
      try_push(16'hE000 + DW'(i), acc);
      if (acc) acc_n++;
    end
    check(acc_n == 0, "R10 R3 pushes ignored", acc_n, 0);
    check(ncmd - c0 == 0, "R10 no command", ncmd - c0, 0);
    @(negedge clk);
    ref_req = 1'b0;
    cyc(2);
    check(ref_ack == 1'b0, "R10 ack released", int'(ref_ack), 0);
    push_n(4, 16'hE100);
    cyc(10);
    check(ncmd - c0 == 1 && c_addr[c0] == 16'h0400, "R10 R4 resumes", int'(c_addr[c0]), 'h400);
    close_xfer();
    cyc(5);
  endtask

  task automatic t_refresh_mid();
    int c0 = ncmd;
    mem_cmd_ready = 1'b0;
    open_xfer(16'h0500);
    push_n(4, 16'hF000);
    cyc(3);
    @(negedge clk);
    ref_req = 1'b1;
    cyc(4);
    #1;
    check(ref_ack == 1'b0, "R10 deferred during burst", int'(ref_ack), 0);
    check(mem_cmd_valid == 1'b1 && mem_cmd_addr == 16'h0500, "R8 cmd held", int'(mem_cmd_addr), 'h500);
    @(negedge clk);
    mem_cmd_ready = 1'b1;
    cyc(10);
    #1;
    check(ref_ack == 1'b1, "R10 taken after burst", int'(ref_ack), 1);
    check(ncmd - c0 == 1, "R10 burst completed", ncmd - c0, 1);
    @(negedge clk);
    ref_req = 1'b0;
    usr_req = 1'b0;
    cyc(8);
  endtask

  initial begin
    rst_n = 1'b0;
    usr_req = 1'b0;
    usr_push = 1'b0;
    usr_data = '0;
    usr_start_addr = '0;
    ref_req = 1'b0;
    mem_cmd_ready = 1'b1;
    cyc(2);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_full_bursts();
    t_short_tail();
    t_backpressure();
    t_refresh_idle();
    t_refresh_mid();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule